// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the reset that a processor sees. It has two causes of reset: a supply-good flag from an outside threshold comparator, taken as an already clean signal, and a manual-reset request that is active low and may come from a bouncing pushbutton. While either cause is present, reset is held. When both causes have cleared, reset stays asserted for a fixed stretch. The stretch is a parameter counted in clock cycles. The reset is driven on two outputs of opposite polarity that always switch together.

The manual-reset input crosses into the clock domain through a synchronizer with a parameter number of stages. No separate debounce logic is needed, because the stretch absorbs any bounce. The stretch timer is held at zero while any cause is present. If a cause comes back before the stretch ends, the release is put off by a full new stretch, counted from the moment that latest cause clears. A one-cycle release strobe marks the first cycle in which the outputs are deasserted.

Top module: `reset_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cpu_rst` is 1, `cpu_rst_n` is 0 and `release_stb` is 0.
- R2: When `supply_ok` is sampled low at a clock edge, reset is asserted from that edge on, and it stays asserted for as long as `supply_ok` stays low, however long that is.
- R3: A low level on `man_rst_n` that spans at least one rising clock edge asserts reset no later than `SYNC_STAGES`+1 edges after the first edge that samples it low.
- R4: Once no cause is present, reset deasserts exactly `HOLD_CYCLES` rising edges after the first edge at which `supply_ok` is high. If the manual request was the last cause, it deasserts exactly `HOLD_CYCLES`+`SYNC_STAGES` edges after the first edge that samples `man_rst_n` high.
- R5: If a cause reappears while the stretch is pending, the stretch restarts in full, counted from the point at which that latest cause clears.
- R6: `cpu_rst_n` is the logical inverse of `cpu_rst` in every cycle.
- R7: `release_stb` is 1 for exactly one cycle, and that cycle is the first one in which `cpu_rst_n` is 1 after being 0. At all other times it is 0.
- R8: A manual-reset low of a single clock cycle starts a complete reset pulse. A bouncing sequence of lows produces a single pulse, which ends one full stretch after the final rise of `man_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| supply_ok | input | 1 | Supply-good flag from the comparator; 1 means the supply is above threshold |
| man_rst_n | input | 1 | Asynchronous manual-reset request, active low; 1 when idle |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |
| release_stb | output | 1 | One-cycle pulse on the first deasserted cycle |

## Verification
The supply-good flag is swept through every drop length from one cycle up to three stretch lengths. This shows that the stretch timer is held at zero while the supply is low, and that it counts only after recovery. The manual request is swept over pulse widths from one to six cycles, and it is also driven with a bounce pattern. These runs separate the added synchronizer latency from the stretch itself, and they show that a single-cycle press is enough to start a full pulse. A second drop is placed at every offset inside a pending stretch, and the two causes are cleared in both orders. Together these runs tell a correct restart-from-latest-cause apart from a timer that resumes or that measures from the first cause.

// File: rtl/sup_pkg.sv
// Package: shared helpers for the reset supervisor.
// Assumes HOLD_CYCLES >= 1 wherever the width function is used.
package sup_pkg;

    // Width needed to count from 0 up to n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Output phase of the supervisor.
    typedef enum logic [0:0] {
        PH_HELD     = 1'b1,
        PH_RELEASED = 1'b0
    } phase_t;

endpackage

// File: rtl/mr_synchronizer.sv
// Module: mr_synchronizer
// What it does: brings the asynchronous manual-reset request into the clock
// domain through a chain of STAGES flops.
// Assumes: STAGES >= 2. In reset, every stage holds 1, which is the idle
// (inactive) level, so no request comes out while the block is in reset.
module mr_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in_n,
    output logic sync_out_n
);
    logic [STAGES-1:0] chain;

    generate
        genvar i;
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Purpose: first stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_in_n;
                end
            end else begin : g_rest
                // Purpose: later stages settle the sampled value.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out_n = chain[STAGES-1];
endmodule

// File: rtl/stretch_counter.sv
// Module: stretch_counter
// What it does: counts the cause-free cycles while reset is still held, and
// flags the cycle on which the hold may end.
// Assumes: HOLD_CYCLES >= 1. The count is cleared while a cause is present or
// while the outputs are already released, so every stretch starts from zero.
module stretch_counter
    import sup_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic held,
    output logic expire
);
    localparam int CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] count;

    // Purpose: flag the final cause-free cycle of the stretch.
    always_comb expire = held && !cause && (count == LAST);

    // Purpose: advance or clear the stretch count.
    always_ff @(posedge clk) begin
        if (!rst_n || cause || !held) count <= '0;
        else if (!expire)             count <= count + 1'b1;
    end
endmodule

// File: rtl/reset_out_stage.sv
// Module: reset_out_stage
// What it does: registers the two reset polarities and the release strobe.
// Assumes: cause and expire are decoded in the same cycle. Both polarities
// are reset to the asserted level.
module reset_out_stage
    import sup_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cause,
    input  logic   expire,
    output logic   rst_hi,
    output logic   rst_lo_n,
    output logic   rel_stb
);
    phase_t next_phase;

    // Purpose: pick the next phase from the causes and the stretch expiry.
    always_comb begin
        if (cause)       next_phase = PH_HELD;
        else if (expire) next_phase = PH_RELEASED;
        else             next_phase = rst_hi ? PH_HELD : PH_RELEASED;
    end

    // Purpose: active-high reset flop.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_hi <= 1'b1;
        else        rst_hi <= (next_phase == PH_HELD);
    end

    // Purpose: active-low reset flop, loaded from the same decision.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_lo_n <= 1'b0;
        else        rst_lo_n <= (next_phase == PH_RELEASED);
    end

    // Purpose: one-cycle strobe on the edge that releases the reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rel_stb <= 1'b0;
        else        rel_stb <= !cause && expire;
    end
endmodule

// File: rtl/reset_supervisor.sv
// Module: reset_supervisor (top)
// What it does: combines the supply-good flag with the synchronized manual
// request, holds reset while either is active, and stretches the release by
// HOLD_CYCLES clocks.
// Assumes: supply_ok is synchronous and clean. man_rst_n may be asynchronous
// and bouncing.
module reset_supervisor #(
    parameter int HOLD_CYCLES = 10_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic man_rst_n,
    output logic cpu_rst_n,
    output logic cpu_rst,
    output logic release_stb
);
    logic man_sync_n;
    logic cause;
    logic expire;

    mr_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in_n (man_rst_n),
        .sync_out_n (man_sync_n)
    );

    // Purpose: any active reset cause.
    always_comb cause = !supply_ok || !man_sync_n;

    stretch_counter #(.HOLD_CYCLES(HOLD_CYCLES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cause  (cause),
        .held   (cpu_rst),
        .expire (expire)
    );

    reset_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause    (cause),
        .expire   (expire),
        .rst_hi   (cpu_rst),
        .rst_lo_n (cpu_rst_n),
        .rel_stb  (release_stb)
    );
endmodule

// File: rtl/reset_supervisor_chk.sv
// Module: reset_supervisor_chk
// What it does: checks port-level timing rules of reset_supervisor.
// Assumes: it is bound to every instance of the top module.
module reset_supervisor_chk #(
    parameter int HOLD_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic man_rst_n,
    input logic cpu_rst_n,
    input logic cpu_rst,
    input logic release_stb
);
    int quiet;

    // Purpose: count consecutive edges that see no cause, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                      quiet <= 0;
        else if (!(supply_ok && man_rst_n)) quiet <= 0;
        else if (quiet < HOLD_CYCLES)    quiet <= quiet + 1;
    end

    assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n != cpu_rst);

    assert_supply_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> cpu_rst);

    assert_strobe_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> release_stb);

    assert_strobe_only_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_stb |-> $rose(cpu_rst_n));

    assert_full_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> (quiet >= HOLD_CYCLES));
endmodule

bind reset_supervisor reset_supervisor_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .man_rst_n   (man_rst_n),
    .cpu_rst_n   (cpu_rst_n),
    .cpu_rst     (cpu_rst),
    .release_stb (release_stb)
);

// File: tb/tb_reset_supervisor.sv
`timescale 1ns/1ps
module tb_reset_supervisor;
    localparam int HOLD = 8;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic man_rst_n = 1'b1;
    logic cpu_rst_n, cpu_rst, release_stb;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reset_supervisor #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
        .cpu_rst_n(cpu_rst_n), .cpu_rst(cpu_rst), .release_stb(release_stb)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {cpu_rst,cpu_rst_n,release_stb} = %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] outs();
        return {cpu_rst, cpu_rst_n, release_stb};
    endfunction

    // Step one edge and sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expect deassertion at exactly 'edges' edges from now; the first 'skip'
    // samples are not checked (synchronizer latency of a new manual request).
    task automatic expect_release(input int edges, input int skip, input string tag);
        for (int n = 1; n <= edges; n++) begin
            step();
            if (n > skip) begin
                if (n < edges) check(tag, outs(), 3'b100);
                else           check({tag, " R7"}, outs(), 3'b011);
            end
        end
        step();
        check("R7 strobe single cycle", outs(), 3'b010);
    endtask

    task automatic supply_drop(input int len);
        supply_ok = 1'b0;
        for (int i = 0; i < len; i++) begin
            step();
            check("R2 held while supply low", outs(), 3'b100);
        end
        supply_ok = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R1 reset state", outs(), 3'b100);
        end
        rst_n = 1'b1;
        // R1 first cycle after reset, then R4 release from power-on
        expect_release(HOLD, 0, "R4 power-on release");

        // R2/R4: every supply drop length up to three stretch lengths
        for (int len = 1; len <= 3 * HOLD; len++) begin
            supply_drop(len);
            expect_release(HOLD, 0, "R4 after supply drop");
        end

        // R3/R8: manual request widths 1..6, release counted with sync latency
        for (int len = 1; len <= 6; len++) begin
            man_rst_n = 1'b0;
            for (int i = 0; i < len; i++) step();
            man_rst_n = 1'b1;
            expect_release(HOLD + SYNC, SYNC, "R3 R8 manual pulse");
        end

        // R5: second supply drop at every offset inside a pending stretch
        for (int k = 1; k < HOLD; k++) begin
            supply_drop(1);
            for (int i = 0; i < k; i++) begin
                step();
                check("R5 still pending", outs(), 3'b100);
            end
            supply_drop(1);
            expect_release(HOLD, 0, "R5 restart from latest cause");
        end

        // R8: bouncing button gives one pulse, measured from the final rise
        begin
            logic [5:0] pat = 6'b010010;
            for (int i = 5; i >= 0; i--) begin
                man_rst_n = pat[i];
                step();
            end
            man_rst_n = 1'b1;
            expect_release(HOLD + SYNC, 0, "R8 bounce");
        end

        // R4: overlapping causes, manual clears first, supply last
        supply_ok = 1'b0; man_rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step();
        man_rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R4 supply still low", outs(), 3'b100);
        end
        supply_ok = 1'b1;
        expect_release(HOLD, 0, "R4 supply last");

        // R4: overlapping causes, supply clears first, manual last
        supply_ok = 1'b0; man_rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step();
        supply_ok = 1'b1;
        step();
        man_rst_n = 1'b1;
        expect_release(HOLD + SYNC, 0, "R4 manual last");

        // R6: idle run, outputs stay released and complementary
        for (int i = 0; i < 10; i++) begin
            step();
            check("R6 idle released", outs(), 3'b010);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule